// File: doc/BRIEF.md
# Gray-Coded Up/Down/Hold Counter

This block is a four-position cyclic counter whose two-bit state code follows a Gray sequence, so that only one state bit toggles on any step. A direction input chooses whether each clock moves the counter forward or backward around the cycle. A hold input freezes the counter whatever the direction input says. Both control inputs may come from unsynchronised sources. Each passes through a flop chain clocked by the block before it reaches the next-state logic.

The block presents its state code directly. It also presents a single flag that is high in the second and fourth positions of the cycle and low in the first and third. The flag is decoded from the state register alone, so it changes only at a clock edge. Reset is synchronous and active low. It returns the counter to the first position and clears the synchroniser.

Top module: `gray_step_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter goes to position A (code 00) with `even_flag` 0, and every synchroniser stage clears to 0. After reset the counter therefore behaves as if both controls were low until new input values have passed through the synchroniser.
- R2: With the synchronised hold at 0 and the synchronised direction at 0, each rising edge moves the counter forward: A=00 → B=01 → C=11 → D=10 → A.
- R3: With the synchronised hold at 0 and the synchronised direction at 1, each rising edge moves the counter backward: A=00 → D=10 → C=11 → B=01 → A.
- R4: With the synchronised hold at 1, the state code does not change at a rising edge, for either value of the direction input.
- R5: `even_flag` is 1 exactly when the code is 01 (B) or 10 (D), and 0 when the code is 00 (A) or 11 (C). It depends on the state only.
- R6: Between two consecutive clock cycles the state code differs in at most one bit.
- R7: A value on `dir_in` or `hold_in` that is sampled at rising edge n governs the update made at rising edge n+2, with the default two-stage synchroniser. A change applied between edges is therefore first visible in `state_code` after the third rising edge.
- R8: The cycle wraps in both directions. Forward, D (10) goes to A (00). Backward, A (00) goes to D (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_in | input | 1 | Direction request, 0 forward and 1 backward; asynchronous |
| hold_in | input | 1 | Hold request, 1 freezes the counter; asynchronous |
| state_code | output | 2 | Gray-coded position: A=00, B=01, C=11, D=10 |
| even_flag | output | 1 | High in positions B and D |

## Verification
The hardest situation to reach from the ports is a direction or hold change that lands exactly on a wrap edge. Every control value takes two extra edges to arrive, so a naive stimulus that looks at the present state is always two steps late. The bench therefore carries its own two-deep delay model of both controls. It sweeps every ordered pair of control patterns over several dwell lengths, so that reversals and hold releases fall at every position, including D→A and A→D. A directed hold-release sequence pins down the three-edge latency, and a reset applied mid-cycle, with hold requested, shows the synchroniser clearing.

// File: rtl/gsc_pkg.sv
// Shared types for the Gray-coded step counter.
// Assumes a fixed four-position cycle; codes are chosen so that neighbours
// differ in exactly one bit.
package gsc_pkg;

    typedef enum logic [1:0] {
        POS_A = 2'b00,
        POS_B = 2'b01,
        POS_C = 2'b11,
        POS_D = 2'b10
    } gsc_pos_t;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'b00,
        MOVE_FWD  = 2'b01,
        MOVE_BACK = 2'b10
    } gsc_move_t;

    localparam int unsigned GSC_CODE_W = 2;

endpackage

// File: rtl/gsc_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous control bits.
// Assumes STAGES >= 2 and that each bit is independent (no bundle coherence
// is promised). All stages clear to 0 on synchronous active-low reset.
module gsc_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_in;
        end
    end

    // Later stages: shift the captured value along the chain.
    for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[gi] <= '0;
            end else begin
                stage_q[gi] <= stage_q[gi-1];
            end
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gsc_move_dec.sv
// Turns the synchronised control bits into a single move command.
// Assumes hold has priority over direction.
module gsc_move_dec
    import gsc_pkg::*;
(
    input  logic      dir_back,
    input  logic      hold,
    output gsc_move_t move
);

    // Priority decode: hold wins, otherwise direction picks the way.
    always_comb begin
        if (hold) begin
            move = MOVE_HOLD;
        end else if (dir_back) begin
            move = MOVE_BACK;
        end else begin
            move = MOVE_FWD;
        end
    end

endmodule

// File: rtl/gsc_next.sv
// Next-position logic for the four-step Gray cycle.
// Assumes the current position is always one of the four legal codes
// (all 2-bit codes are legal, so no recovery path is needed).
module gsc_next
    import gsc_pkg::*;
(
    input  gsc_pos_t  cur,
    input  gsc_move_t move,
    output gsc_pos_t  nxt
);

    gsc_pos_t fwd_pos;
    gsc_pos_t back_pos;

    // Forward neighbour of each position.
    always_comb begin
        unique case (cur)
            POS_A:   fwd_pos = POS_B;
            POS_B:   fwd_pos = POS_C;
            POS_C:   fwd_pos = POS_D;
            default: fwd_pos = POS_A;
        endcase
    end

    // Backward neighbour of each position.
    always_comb begin
        unique case (cur)
            POS_A:   back_pos = POS_D;
            POS_D:   back_pos = POS_C;
            POS_C:   back_pos = POS_B;
            default: back_pos = POS_A;
        endcase
    end

    // Select the neighbour named by the move command.
    always_comb begin
        unique case (move)
            MOVE_FWD:  nxt = fwd_pos;
            MOVE_BACK: nxt = back_pos;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/gray_step_counter.sv
// Four-position Gray-coded counter with direction and hold controls.
// Assumes dir_in and hold_in are asynchronous; both pass through a
// SYNC_STAGES-deep synchroniser. The flag output is a Moore decode of the
// registered state only.
module gray_step_counter
    import gsc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_in,
    input  logic       hold_in,
    output logic [1:0] state_code,
    output logic       even_flag
);

    localparam int unsigned CTRL_W = 2;

    logic [CTRL_W-1:0] ctrl_s;
    logic              dir_s;
    logic              hold_s;
    gsc_move_t         move;
    gsc_pos_t          pos_q;
    gsc_pos_t          pos_d;

    gsc_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (CTRL_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({hold_in, dir_in}),
        .sync_out (ctrl_s)
    );

    assign dir_s  = ctrl_s[0];
    assign hold_s = ctrl_s[1];

    gsc_move_dec u_move (
        .dir_back (dir_s),
        .hold     (hold_s),
        .move     (move)
    );

    gsc_next u_next (
        .cur  (pos_q),
        .move (move),
        .nxt  (pos_d)
    );

    // State memory: D flops loaded from the next-position logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_A;
        end else begin
            pos_q <= pos_d;
        end
    end

    // Moore output: high in the second and fourth positions.
    always_comb begin
        unique case (pos_q)
            POS_B, POS_D: even_flag = 1'b1;
            default:      even_flag = 1'b0;
        endcase
    end

    assign state_code = pos_q;

endmodule

// File: rtl/gsc_checker.sv
// Property checker for gray_step_counter, bound into every instance.
// Observes the synchronised controls and the outputs.
module gsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_s,
    input logic       hold_s,
    input logic [1:0] state_code,
    input logic       even_flag
);

    function automatic logic [1:0] to_bin(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    // R1
    reset_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_code == 2'b00 && !even_flag));

    // R2
    fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !dir_s) |=> (to_bin(state_code) == to_bin($past(state_code)) + 2'd1));

    // R3
    back_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && dir_s) |=> (to_bin(state_code) == to_bin($past(state_code)) - 2'd1));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> $stable(state_code));

    // R5
    flag_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> (even_flag != $past(even_flag)));

    // R5
    flag_low_in_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b00) |-> !even_flag);

    // R6
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_code ^ $past(state_code)) <= 1);

    // R8
    wrap_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10 && !hold_s && !dir_s) |=> (state_code == 2'b00));

    // R8
    wrap_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b00 && !hold_s && dir_s) |=> (state_code == 2'b10));

endmodule

bind gray_step_counter gsc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_s      (dir_s),
    .hold_s     (hold_s),
    .state_code (state_code),
    .even_flag  (even_flag)
);

// File: tb/sim_gray_step_counter.sv
module sim_gray_step_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_in = 1'b0;
    logic       s_in = 1'b0;
    logic [1:0] code;
    logic       yflag;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    gray_step_counter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_in     (m_in),
        .hold_in    (s_in),
        .state_code (code),
        .even_flag  (yflag)
    );

    always #10 clk = ~clk;

    // Bench model: position index 0..3 plus a two-deep control delay.
    int   idx = 0;
    logic d1m = 0, d1s = 0, d2m = 0, d2s = 0;
    int   kind = 0;   // 0 reset, 1 hold, 2 forward, 3 backward
    bit   wrapped = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            idx <= 0; d1m <= 0; d1s <= 0; d2m <= 0; d2s <= 0;
            kind <= 0; wrapped <= 0;
        end else begin
            d1m <= m_in; d1s <= s_in; d2m <= d1m; d2s <= d1s;
            if (d2s) begin
                kind <= 1; wrapped <= 0;
            end else if (!d2m) begin
                idx <= (idx + 1) % 4; kind <= 2; wrapped <= (idx == 3);
            end else begin
                idx <= (idx + 3) % 4; kind <= 3; wrapped <= (idx == 0);
            end
        end
    end

    function automatic logic [1:0] gray_of(input int i);
        logic [1:0] b;
        b = i[1:0];
        return b ^ (b >> 1);
    endfunction

    task automatic report(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle checks against the model, sampled on the falling edge.
    logic [1:0] prev_code = 2'b00;
    bit prev_ok = 0;
    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            string tag;
            if (wrapped) tag = "R8";
            else if (kind == 1) tag = "R4";
            else if (kind == 2) tag = "R2";
            else if (kind == 3) tag = "R3";
            else tag = "R1";
            report(tag, code, gray_of(idx));
            report("R5", {1'b0, yflag}, {1'b0, idx[0]});
            if (prev_ok) begin
                checks++;
                if ($countones(code ^ prev_code) > 1) begin
                    fails++;
                    $display("FAIL R6 t=%0t actual=%b expected one-bit step from %b", $time, code, prev_code);
                end
            end
            prev_code = code;
            prev_ok = 1;
        end else begin
            prev_ok = 0;
        end
    end

    task automatic run(input logic m, input logic s, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            m_in = m;
            s_in = s;
        end
    endtask

    task automatic do_reset(input logic m, input logic s);
        @(negedge clk);
        rst_n = 1'b0; m_in = m; s_in = s;
        repeat (3) @(negedge clk);
        report("R1", code, 2'b00);
        report("R1", {1'b0, yflag}, 2'b00);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(1'b0, 1'b0);
        chk_en = 1'b1;

        // R2 and R8: free forward run through several wraps.
        run(1'b0, 1'b0, 10);
        // R3 and R8: free backward run.
        run(1'b1, 1'b0, 10);
        // R4: hold with both directions.
        run(1'b0, 1'b1, 6);
        run(1'b1, 1'b1, 6);

        // R7: exact latency of a hold release.
        begin
            logic [1:0] frozen;
            run(1'b0, 1'b1, 5);
            frozen = code;
            @(negedge clk); s_in = 1'b0;       // change between edges
            @(negedge clk); report("R7", code, frozen);   // after edge 1
            @(negedge clk); report("R7", code, frozen);   // after edge 2
            @(negedge clk); report("R7", code, gray_of((int'(to_idx(frozen)) + 1) % 4)); // after edge 3
        end

        // Sweep every ordered pair of control patterns at several dwells.
        for (int len = 1; len <= 5; len++) begin
            for (int p = 0; p < 4; p++) begin
                for (int q = 0; q < 4; q++) begin
                    run(p[0], p[1], len);
                    run(q[0], q[1], len);
                end
            end
        end

        // Pseudo-random control stream from an 8-bit LFSR.
        begin
            logic [7:0] lf = 8'hA5;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                run(lf[0], lf[1] & lf[2], 1);
            end
        end

        // R1: reset mid-cycle with hold requested, then release.
        run(1'b0, 1'b0, 2);
        chk_en = 1'b0;
        do_reset(1'b1, 1'b1);
        chk_en = 1'b1;
        run(1'b1, 1'b1, 8);
        run(1'b0, 1'b0, 8);

        @(negedge clk);
        chk_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int to_idx(input logic [1:0] g);
        case (g)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule